// File: doc/BRIEF.md
# Phase-Continuous Ratio NCO

This block is a numerically controlled oscillator meant to sit at the end of a phase-tracking loop. Its frequency word is the sum of a fixed centre word and a signed correction supplied by a loop controller. The word is committed only when an update strobe is accepted. A 32-bit phase accumulator adds the committed word on every clock. It is never cleared or reloaded by an update, so a retune changes only the slope of the phase and never its value. The committed word is always visible on a readback port, which lets the block double as a frequency counter for the tracked signal.

A second accumulator runs at m/n times the tracked frequency, for demodulation at a harmonic or at a fraction of the tracked frequency. On each accepted update the block starts a sequential divider that splits m·word by n into an integer step and a remainder. The remainder feeds a carry accumulator modulo n, so the secondary phase does not drift over time. Until the division finishes, the secondary accumulator keeps its previous step. A divisor of zero cannot be used: such an update is dropped and an error flag is raised.

Top module: `ratio_nco`

## Requirements
- R1: After synchronous reset, phase_main, phase_ratio and freq_word are zero and ratio_err is low.
- R2: An update with div_n not zero loads freq_word with center_word plus feedback, where feedback is two's complement and the sum wraps modulo 2^32. The new value is visible from the clock after the strobe and is held until the next accepted update.
- R3: The main accumulator adds freq_word on every clock, and phase_main is its upper 16 bits. At the edge that samples an update, the old word is still added. From the next edge on, the new word is added. No other step value ever occurs.
- R4: Once the secondary step has settled, phase_ratio (the upper 16 bits of the secondary accumulator) advances over any window of n·2^k clocks by exactly m·freq_word·window/n modulo 2^32. The quotient m·freq_word/n is added every clock, and the remainder is carried modulo n.
- R5: After an accepted update the secondary accumulator keeps stepping by its previous step and is not reloaded. It switches to the new step within 48 clocks and keeps it after that.
- R6: An update with div_n equal to zero changes neither freq_word nor either step, and raises ratio_err. ratio_err stays high until the next accepted update, which clears it.
- R7: An accepted update that arrives while a division is still running restarts the division. The secondary step that settles is the one belonging to the latest update.
- R8: m larger than n produces a harmonic step, for example m=3 and n=1 gives three times the main step. m equal to zero stops the secondary phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| center_word | input | 32 | Centre frequency word |
| feedback | input | 32 | Signed controller correction added to the centre word |
| update | input | 1 | Strobe that commits a new frequency word and ratio |
| mult_m | input | 8 | Ratio numerator m |
| div_n | input | 8 | Ratio denominator n; zero is rejected |
| phase_main | output | 16 | Upper bits of the main phase accumulator |
| phase_ratio | output | 16 | Upper bits of the m/n phase accumulator |
| freq_word | output | 32 | Committed frequency word (counter readback) |
| ratio_err | output | 1 | Set by an update with n equal to zero |

## Verification
The hardest point to reach from the ports is the remainder carry. Only 16 phase bits leave the block, so a fractional carry is hidden unless the window is chosen so that the total advance is an exact multiple of 2^16. The bench therefore picks frequency words and windows of n·2^k clocks (n=3 and n=5, with remainders that are not zero) where the exact advance falls on the visible bits, and compares both phase outputs to 64-bit arithmetic. Step changes are checked cycle by cycle around the strobe. A second update issued ten clocks into a division tells a restart apart from an update that was dropped.

// File: rtl/ratio_nco_pkg.sv
package ratio_nco_pkg;
  localparam int unsigned NCO_ACC_W = 32;
  localparam int unsigned NCO_PH_W  = 16;
  localparam int unsigned NCO_RAT_W = 8;
  localparam int unsigned NCO_LANES = 2;

  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/ratio_divider.sv
module ratio_divider
  import ratio_nco_pkg::*;
#(
  parameter int unsigned DVD_W = 40,
  parameter int unsigned DVS_W = 8,
  parameter int unsigned Q_W   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic [Q_W-1:0]   quotient,
  output logic [DVS_W-1:0] remainder,
  output logic             done
);
  localparam int unsigned CNT_W = $clog2(DVD_W + 1);

  div_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [DVD_W-1:0] quo;
  logic [DVS_W-1:0] rem;
  logic [DVS_W-1:0] dvs;
  logic [DVS_W:0]   trial;
  logic [DVS_W:0]   trial_sub;
  logic             fits;

  // One restoring step per clock: shift in the next dividend bit, subtract if it fits.
  always_comb begin
    trial     = {rem, quo[DVD_W-1]};
    fits      = trial >= {1'b0, dvs};
    trial_sub = trial - {1'b0, dvs};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= DIV_IDLE;
      cnt   <= '0;
      quo   <= '0;
      rem   <= '0;
      dvs   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quo   <= dividend;
        rem   <= '0;
        dvs   <= divisor;
        cnt   <= CNT_W'(DVD_W);
        state <= DIV_RUN;
      end else if (state == DIV_RUN) begin
        quo <= {quo[DVD_W-2:0], fits};
        rem <= fits ? trial_sub[DVS_W-1:0] : trial[DVS_W-1:0];
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          state <= DIV_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quotient  = quo[Q_W-1:0];
  assign remainder = rem;
endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned MOD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] step,
  input  logic [MOD_W-1:0] frac_step,
  input  logic [MOD_W-1:0] modulus,
  input  logic             frac_clr,
  output logic [ACC_W-1:0] acc,
  output logic [MOD_W-1:0] frac
);
  logic [MOD_W:0]   frac_sum;
  logic             carry;
  logic [MOD_W-1:0] frac_next;

  // Remainder residue modulo `modulus`; a wrap adds one extra count to the phase.
  always_comb begin
    frac_sum  = {1'b0, frac} + {1'b0, frac_step};
    carry     = frac_sum >= {1'b0, modulus};
    frac_next = carry ? MOD_W'(frac_sum - {1'b0, modulus}) : frac_sum[MOD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      frac <= '0;
    end else begin
      acc  <= acc + step + ACC_W'(carry);
      frac <= frac_clr ? '0 : frac_next;
    end
  end
endmodule

// File: rtl/ratio_nco.sv
module ratio_nco
  import ratio_nco_pkg::*;
#(
  parameter int unsigned ACC_W = NCO_ACC_W,
  parameter int unsigned PH_W  = NCO_PH_W,
  parameter int unsigned RAT_W = NCO_RAT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] center_word,
  input  logic [ACC_W-1:0] feedback,
  input  logic             update,
  input  logic [RAT_W-1:0] mult_m,
  input  logic [RAT_W-1:0] div_n,
  output logic [PH_W-1:0]  phase_main,
  output logic [PH_W-1:0]  phase_ratio,
  output logic [ACC_W-1:0] freq_word,
  output logic             ratio_err
);
  localparam int unsigned PROD_W = ACC_W + RAT_W;
  localparam int unsigned LANES  = NCO_LANES;

  logic [ACC_W-1:0]  word_r;
  logic [ACC_W-1:0]  next_word;
  logic [PROD_W-1:0] dividend;
  logic              accept;
  logic              reject;
  logic              err_r;

  logic [ACC_W-1:0]  div_quo;
  logic [RAT_W-1:0]  div_rem;
  logic              div_done;

  logic [ACC_W-1:0]  q_step;
  logic [RAT_W-1:0]  r_step;
  logic [RAT_W-1:0]  n_cur;
  logic [RAT_W-1:0]  pend_n;

  logic [ACC_W-1:0]  step_arr  [LANES];
  logic [RAT_W-1:0]  fstep_arr [LANES];
  logic [RAT_W-1:0]  mod_arr   [LANES];
  logic              clr_arr   [LANES];
  logic [ACC_W-1:0]  acc_arr   [LANES];
  logic [RAT_W-1:0]  frac_arr  [LANES];

  always_comb begin
    next_word = center_word + feedback;
    accept    = update && (div_n != '0);
    reject    = update && (div_n == '0);
    dividend  = PROD_W'(mult_m) * PROD_W'(next_word);
  end

  ratio_divider #(
    .DVD_W(PROD_W),
    .DVS_W(RAT_W),
    .Q_W  (ACC_W)
  ) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .dividend (dividend),
    .divisor  (div_n),
    .quotient (div_quo),
    .remainder(div_rem),
    .done     (div_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_r <= '0;
      q_step <= '0;
      r_step <= '0;
      n_cur  <= RAT_W'(1);
      pend_n <= RAT_W'(1);
      err_r  <= 1'b0;
    end else begin
      if (accept) begin
        word_r <= next_word;
        pend_n <= div_n;
        err_r  <= 1'b0;
      end else if (reject) begin
        err_r  <= 1'b1;
      end
      if (div_done) begin
        q_step <= div_quo;
        r_step <= div_rem;
        n_cur  <= pend_n;
      end
    end
  end

  // Lane 0 tracks the committed word; lane 1 runs at m/n with remainder carry.
  always_comb begin
    step_arr[0]  = word_r;
    fstep_arr[0] = '0;
    mod_arr[0]   = RAT_W'(1);
    clr_arr[0]   = 1'b0;
    step_arr[1]  = q_step;
    fstep_arr[1] = r_step;
    mod_arr[1]   = n_cur;
    clr_arr[1]   = div_done;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    phase_accum #(
      .ACC_W(ACC_W),
      .MOD_W(RAT_W)
    ) u_acc (
      .clk      (clk),
      .rst      (rst),
      .step     (step_arr[g]),
      .frac_step(fstep_arr[g]),
      .modulus  (mod_arr[g]),
      .frac_clr (clr_arr[g]),
      .acc      (acc_arr[g]),
      .frac     (frac_arr[g])
    );
  end

  assign phase_main  = acc_arr[0][ACC_W-1 -: PH_W];
  assign phase_ratio = acc_arr[1][ACC_W-1 -: PH_W];
  assign freq_word   = word_r;
  assign ratio_err   = err_r;
endmodule

// File: rtl/ratio_nco_chk.sv
module ratio_nco_chk #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned RAT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             update,
  input logic [RAT_W-1:0] div_n,
  input logic [ACC_W-1:0] freq_word,
  input logic             ratio_err,
  input logic [RAT_W-1:0] n_cur,
  input logic [ACC_W-1:0] acc_all  [2],
  input logic [RAT_W-1:0] frac_all [2]
);
  logic live;

  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  p_main_step_r3: assert property (@(posedge clk) disable iff (rst)
    live |-> acc_all[0] == $past(acc_all[0]) + $past(freq_word));

  p_word_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (live && !$past(update)) |-> $stable(freq_word));

  p_reject_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (update && div_n == '0) |=> (ratio_err && $stable(freq_word)));

  p_accept_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (update && div_n != '0) |=> !ratio_err);

  p_err_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (live && !$past(update)) |-> $stable(ratio_err));

  p_frac_bound_r4: assert property (@(posedge clk) disable iff (rst)
    frac_all[1] < n_cur);

  p_main_no_frac_r3: assert property (@(posedge clk) disable iff (rst)
    frac_all[0] == '0);
endmodule

bind ratio_nco ratio_nco_chk #(
  .ACC_W(ACC_W),
  .RAT_W(RAT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .update   (update),
  .div_n    (div_n),
  .freq_word(freq_word),
  .ratio_err(ratio_err),
  .n_cur    (n_cur),
  .acc_all  (acc_arr),
  .frac_all (frac_arr)
);

// File: tb/ratio_nco_test.sv
`timescale 1ns/1ps
module ratio_nco_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] center_word = '0;
  logic [31:0] feedback = '0;
  logic        update = 1'b0;
  logic [7:0]  mult_m = 8'd1;
  logic [7:0]  div_n = 8'd1;
  logic [15:0] phase_main;
  logic [15:0] phase_ratio;
  logic [31:0] freq_word;
  logic        ratio_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ratio_nco uut (
    .clk(clk), .rst(rst), .center_word(center_word), .feedback(feedback),
    .update(update), .mult_m(mult_m), .div_n(div_n), .phase_main(phase_main),
    .phase_ratio(phase_ratio), .freq_word(freq_word), .ratio_err(ratio_err)
  );

  task automatic check_eq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Strobe sampled at one edge; returns at the falling edge just after it.
  task automatic pulse_update(input logic [31:0] c, input logic [31:0] f,
                              input logic [7:0] m, input logic [7:0] n);
    @(negedge clk);
    center_word = c; feedback = f; mult_m = m; div_n = n; update = 1'b1;
    @(negedge clk);
    update = 1'b0;
  endtask

  task automatic settle(input logic [31:0] w, input logic [7:0] m, input logic [7:0] n);
    pulse_update(w, 32'h0, m, n);
    repeat (60) @(negedge clk);
  endtask

  task automatic t_reset;
    check_eq("R1 phase_main after reset", phase_main, 0);
    check_eq("R1 phase_ratio after reset", phase_ratio, 0);
    check_eq("R1 freq_word after reset", freq_word, 0);
    check_eq("R1 ratio_err after reset", ratio_err, 0);
  endtask

  task automatic t_readback;
    pulse_update(32'h0200_0000, 32'hFF80_0000, 8'd1, 8'd1);
    check_eq("R2 freq_word centre plus negative feedback", freq_word, 32'h0180_0000);
    repeat (50) @(negedge clk);
    check_eq("R2 freq_word held without update", freq_word, 32'h0180_0000);
    pulse_update(32'h0100_0000, 32'h0000_0010, 8'd1, 8'd1);
    check_eq("R2 freq_word centre plus positive feedback", freq_word, 32'h0100_0010);
  endtask

  task automatic t_continuity;
    logic [15:0] prev_m, prev_r, cur_m, cur_r, d;
    int switch_at;
    bit bad_r5;
    settle(32'h0100_0000, 8'd2, 8'd1);
    prev_m = phase_main; prev_r = phase_ratio;
    center_word = 32'h0300_0000; feedback = '0; mult_m = 8'd2; div_n = 8'd1;
    update = 1'b1;
    @(negedge clk);
    update = 1'b0;
    cur_m = phase_main; cur_r = phase_ratio;
    d = cur_m - prev_m;
    check_eq("R3 main step on strobe edge is old word", d, 16'h0100);
    d = cur_r - prev_r;
    check_eq("R5 ratio step on strobe edge is old", d, 16'h0200);
    switch_at = -1; bad_r5 = 1'b0;
    for (int i = 1; i <= 60; i++) begin
      prev_m = cur_m; prev_r = cur_r;
      @(negedge clk);
      cur_m = phase_main; cur_r = phase_ratio;
      if (i <= 4) begin
        d = cur_m - prev_m;
        check_eq("R3 main step after strobe is new word", d, 16'h0300);
      end
      d = cur_r - prev_r;
      if (d == 16'h0600) begin
        if (switch_at < 0) switch_at = i;
      end else if (d == 16'h0200) begin
        if (switch_at >= 0) bad_r5 = 1'b1;
      end else begin
        bad_r5 = 1'b1;
      end
    end
    check_eq("R5 ratio steps only old or new, no return", bad_r5, 0);
    check_eq("R5 ratio switched within 48 clocks", (switch_at > 0 && switch_at <= 48), 1);
  endtask

  task automatic t_harmonic;
    logic [15:0] a, b;
    settle(32'h0040_0000, 8'd3, 8'd1);
    for (int i = 0; i < 3; i++) begin
      a = phase_ratio;
      @(negedge clk);
      b = phase_ratio;
      check_eq("R8 harmonic m=3 n=1 step", 16'(b - a), 16'h00C0);
    end
    settle(32'h0040_0000, 8'd0, 8'd1);
    a = phase_ratio;
    repeat (10) @(negedge clk);
    check_eq("R8 m=0 stops ratio phase", phase_ratio, a);
  endtask

  task automatic t_window(input logic [31:0] w, input logic [7:0] m, input logic [7:0] n,
                          input int win);
    logic [15:0] m0, r0;
    longint exp_m, exp_r;
    settle(w, m, n);
    m0 = phase_main; r0 = phase_ratio;
    repeat (win) @(negedge clk);
    exp_m = ((longint'(w) * win) >> 16) & 64'hFFFF;
    exp_r = (((longint'(m) * longint'(w) * win) / n) >> 16) & 64'hFFFF;
    check_eq("R3 main advance over window", 16'(phase_main - m0), exp_m);
    check_eq("R4 ratio advance over n*2^k window", 16'(phase_ratio - r0), exp_r);
  endtask

  task automatic t_zero_div;
    logic [15:0] a, b;
    settle(32'h0100_0000, 8'd1, 8'd1);
    pulse_update(32'h0500_0000, 32'h0, 8'd1, 8'd0);
    check_eq("R6 ratio_err raised by n=0", ratio_err, 1);
    check_eq("R6 freq_word unchanged by n=0", freq_word, 32'h0100_0000);
    repeat (60) @(negedge clk);
    a = phase_ratio; b = phase_main;
    @(negedge clk);
    check_eq("R6 ratio step unchanged by n=0", 16'(phase_ratio - a), 16'h0100);
    check_eq("R6 main step unchanged by n=0", 16'(phase_main - b), 16'h0100);
    check_eq("R6 ratio_err held", ratio_err, 1);
    pulse_update(32'h0100_0000, 32'h0, 8'd1, 8'd1);
    check_eq("R6 ratio_err cleared by accepted update", ratio_err, 0);
  endtask

  task automatic t_restart;
    logic [15:0] a;
    settle(32'h0100_0000, 8'd1, 8'd1);
    pulse_update(32'h0200_0000, 32'h0, 8'd1, 8'd1);
    repeat (9) @(negedge clk);
    pulse_update(32'h0400_0000, 32'h0, 8'd1, 8'd1);
    repeat (60) @(negedge clk);
    a = phase_ratio;
    @(negedge clk);
    check_eq("R7 restarted division uses latest word", 16'(phase_ratio - a), 16'h0400);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1-all actual=%0d expected=%0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_readback();
    t_continuity();
    t_harmonic();
    t_window(32'h00A1_B2C4, 8'd2, 8'd3, 3 * 16384);
    t_window(32'h0012_3458, 8'd7, 8'd5, 5 * 8192);
    t_zero_div();
    t_restart();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule